// File: doc/BRIEF.md
# Majority Coincidence Trigger Unit

This block forms layer coincidences for hits from multi-layer detector chambers. Each trigger channel has one hit bit per layer, with up to four layers. The unit delays every layer by a programmable number of bunch-crossing clocks so that hits from the same particle line up. It then counts, for each channel, how many of the active layers saw a hit. A channel fires when that count reaches a majority threshold. The result is a per-channel trigger vector, registered on the bunch-crossing clock.

A mode input selects one of five chamber types. The type sets how many layers take part and the default majority level:

| Type | Active layers | Default majority |
|------|---------------|------------------|
| Wire doublet | four | three of four |
| Strip doublet | four | three of four |
| Wire triplet | three | two of three |
| Strip triplet | two | one of two |
| Inner/forward | two | one of two |

A threshold input can replace the default with any level from one up to the number of active layers. The per-layer delays and the threshold are static configuration inputs. They can be changed at any time, so one instance can be exercised across many settings.

Top module: `coinc_majority_top`

## Requirements
- R1: While `rst_n` is low, `trig_out` is all zeros. Hits presented during reset never appear at the output after reset is released.
- R2: With `mode_sel` = 0 (wire doublet) and `thr_cfg` = 0, a channel fires when at least three of layers 0..3 carry a hit.
- R3: With `mode_sel` = 1 (wire triplet) and `thr_cfg` = 0, a channel fires when at least two of layers 0..2 carry a hit. Layer 3 has no effect.
- R4: With `mode_sel` = 2 (strip doublet) and `thr_cfg` = 0, a channel fires when at least three of layers 0..3 carry a hit.
- R5: With `mode_sel` = 3 (strip triplet) or 4 (inner/forward) and `thr_cfg` = 0, a channel fires when layer 0 or layer 1 carries a hit. Layers 2 and 3 have no effect.
- R6: A nonzero `thr_cfg` replaces the default threshold with min(`thr_cfg`, number of active layers).
- R7: Layer L uses the delay d in `dly_cfg[4L+3:4L]`, which ranges from 0 to 15. Its hit sampled at clock edge k takes part in the decision registered at edge k+d, so the latency is d plus one cycle. Mode and threshold are taken from the same edge as the decision. Channel c of layer L is bit `hit_in[8L+c]`.
- R8: `mode_sel` values 5, 6 and 7 force the next registered `trig_out` to all zeros.
- R9: Each channel's decision depends only on that channel's own hit bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Chamber type: 0 wire doublet, 1 wire triplet, 2 strip doublet, 3 strip triplet, 4 inner/forward |
| thr_cfg | input | 3 | Threshold override; 0 selects the type default |
| dly_cfg | input | 16 | Four-bit delay per layer, layer L at bits 4L+3:4L |
| hit_in | input | 32 | Masked hits, layer L channel c at bit 8L+c |
| trig_out | output | 8 | Registered per-channel coincidence result |

## Verification
The hardest case to reach from the ports is a coincidence whose hits enter on different cycles and line up only through unequal layer delays. A related case is a delay setting that changes while earlier hits are still in the shift lines. To reach both, the stimulus keeps the hit density near one half, so every layer count from zero to four occurs often. It redraws all four delays every eight cycles without flushing the lines. The bench model keeps its own sixteen-deep history of the sampled hit vectors. It indexes that history by each layer's current delay, so every mixed-age alignment is predicted and checked.

// File: rtl/coinc_pkg.sv
package coinc_pkg;

   localparam int NLAYER = 4;
   localparam int THR_W  = $clog2(NLAYER + 1);
   localparam int MODE_W = 3;

   typedef enum logic [MODE_W-1:0] {
      MODE_WIRE_DBL  = 3'd0,
      MODE_WIRE_TRP  = 3'd1,
      MODE_STRIP_DBL = 3'd2,
      MODE_STRIP_TRP = 3'd3,
      MODE_INNER     = 3'd4
   } chamber_mode_e;

   typedef struct packed {
      logic              valid;
      logic [NLAYER-1:0] layer_en;
      logic [THR_W-1:0]  thr;
   } coinc_cfg_t;

endpackage

// File: rtl/coinc_delay_line.sv
module coinc_delay_line #(
   parameter int NCH   = 8,
   parameter int DLY_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NCH-1:0]   din,
   input  logic [DLY_W-1:0] sel,
   output logic [NCH-1:0]   dout
);
   localparam int DEPTH = (1 << DLY_W) - 1;

   generate
      if (DEPTH == 1) begin : g_single
         logic [NCH-1:0] stage_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= '0;
            else        stage_q <= din;
         end

         always_comb dout = (sel == '0) ? din : stage_q;
      end else begin : g_chain
         logic [NCH-1:0] stage_q [DEPTH];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int j = 0; j < DEPTH; j++) stage_q[j] <= '0;
            end else begin
               stage_q[0] <= din;
               for (int j = 1; j < DEPTH; j++) stage_q[j] <= stage_q[j-1];
            end
         end

         always_comb begin
            if (sel == '0) dout = din;
            else           dout = stage_q[sel - DLY_W'(1)];
         end
      end
   endgenerate
endmodule

// File: rtl/coinc_mode_decode.sv
module coinc_mode_decode
   import coinc_pkg::*;
(
   input  logic [MODE_W-1:0] mode_sel,
   input  logic [THR_W-1:0]  thr_cfg,
   output coinc_cfg_t        cfg
);
   logic [THR_W-1:0]  n_used;
   logic [THR_W-1:0]  thr_dflt;
   logic [NLAYER-1:0] en;
   logic              known;

   always_comb begin
      known    = 1'b1;
      n_used   = THR_W'(NLAYER);
      thr_dflt = THR_W'(NLAYER - 1);
      en       = '1;
      case (mode_sel)
         MODE_WIRE_DBL, MODE_STRIP_DBL: begin
            n_used   = THR_W'(4);
            thr_dflt = THR_W'(3);
            en       = 4'b1111;
         end
         MODE_WIRE_TRP: begin
            n_used   = THR_W'(3);
            thr_dflt = THR_W'(2);
            en       = 4'b0111;
         end
         MODE_STRIP_TRP, MODE_INNER: begin
            n_used   = THR_W'(2);
            thr_dflt = THR_W'(1);
            en       = 4'b0011;
         end
         default: begin
            known = 1'b0;
            en    = '0;
         end
      endcase
   end

   always_comb begin
      cfg.valid    = known;
      cfg.layer_en = en;
      if (thr_cfg == '0)        cfg.thr = thr_dflt;
      else if (thr_cfg > n_used) cfg.thr = n_used;
      else                      cfg.thr = thr_cfg;
   end
endmodule

// File: rtl/coinc_majority.sv
module coinc_majority
   import coinc_pkg::*;
#(
   parameter int NCH = 8
) (
   input  logic [NLAYER*NCH-1:0] dly_hits,
   input  coinc_cfg_t            cfg,
   output logic [NCH-1:0]        fire
);
   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [NLAYER-1:0] col;
      logic [THR_W-1:0]  cnt;

      for (genvar l = 0; l < NLAYER; l++) begin : g_lay
         assign col[l] = dly_hits[l*NCH + c] & cfg.layer_en[l];
      end

      always_comb begin
         cnt = '0;
         for (int l = 0; l < NLAYER; l++) cnt = cnt + THR_W'(col[l]);
      end

      assign fire[c] = cfg.valid && (cnt >= cfg.thr);
   end
endmodule

// File: rtl/coinc_majority_top.sv
module coinc_majority_top
   import coinc_pkg::*;
#(
   parameter int NCH   = 8,
   parameter int DLY_W = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [MODE_W-1:0]       mode_sel,
   input  logic [THR_W-1:0]        thr_cfg,
   input  logic [NLAYER*DLY_W-1:0] dly_cfg,
   input  logic [NLAYER*NCH-1:0]   hit_in,
   output logic [NCH-1:0]          trig_out
);
   if (NCH < 1) begin : g_bad_nch
      $error("coinc_majority_top: NCH must be at least 1");
   end
   if (DLY_W < 1 || DLY_W > 6) begin : g_bad_dly
      $error("coinc_majority_top: DLY_W must lie in 1..6");
   end

   logic [NLAYER*NCH-1:0] aligned;
   coinc_cfg_t            cfg;
   logic [NCH-1:0]        fire;

   for (genvar l = 0; l < NLAYER; l++) begin : g_layer
      coinc_delay_line #(
         .NCH   (NCH),
         .DLY_W (DLY_W)
      ) u_dly (
         .clk   (clk),
         .rst_n (rst_n),
         .din   (hit_in[l*NCH +: NCH]),
         .sel   (dly_cfg[l*DLY_W +: DLY_W]),
         .dout  (aligned[l*NCH +: NCH])
      );
   end

   coinc_mode_decode u_mode (
      .mode_sel (mode_sel),
      .thr_cfg  (thr_cfg),
      .cfg      (cfg)
   );

   coinc_majority #(
      .NCH (NCH)
   ) u_maj (
      .dly_hits (aligned),
      .cfg      (cfg),
      .fire     (fire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trig_out <= '0;
      else        trig_out <= fire;
   end
endmodule

// File: rtl/coinc_majority_chk.sv
module coinc_majority_chk
   import coinc_pkg::*;
#(
   parameter int NCH   = 8,
   parameter int DLY_W = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [MODE_W-1:0]       mode_sel,
   input logic [THR_W-1:0]        thr_cfg,
   input logic [NLAYER*DLY_W-1:0] dly_cfg,
   input logic [NLAYER*NCH-1:0]   hit_in,
   input logic [NCH-1:0]          trig_out
);
   localparam int MAXD = (1 << DLY_W) - 1;

   int             quiet_cnt;
   logic [NCH-1:0] exp_dbl;
   logic [NCH-1:0] exp_or2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                quiet_cnt <= 0;
      else if (hit_in != '0)     quiet_cnt <= 0;
      else if (quiet_cnt < MAXD) quiet_cnt <= quiet_cnt + 1;
   end

   always_comb begin
      for (int c = 0; c < NCH; c++) begin
         int n;
         n = 0;
         for (int l = 0; l < 4; l++) n = n + int'(hit_in[l*NCH + c]);
         exp_dbl[c] = (n >= 3);
         exp_or2[c] = hit_in[c] | hit_in[NCH + c];
      end
   end

   AST_BAD_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel > 3'd4) |=> (trig_out == '0)); // R8

   AST_QUIET_NO_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet_cnt >= MAXD && hit_in == '0) |=> (trig_out == '0)); // R7

   AST_DOUBLET_MAJ: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel == 3'd0 && thr_cfg == '0 && dly_cfg == '0) |=> (trig_out == $past(exp_dbl))); // R2

   AST_STRIP_DBL_MAJ: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel == 3'd2 && thr_cfg == '0 && dly_cfg == '0) |=> (trig_out == $past(exp_dbl))); // R4

   AST_INNER_ANY: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel == 3'd4 && thr_cfg == '0 && dly_cfg == '0) |=> (trig_out == $past(exp_or2))); // R5

   always @(posedge clk) begin
      if (!rst_n) begin
         AST_RESET_CLEAR: assert (trig_out == '0); // R1
      end
   end
endmodule

bind coinc_majority_top coinc_majority_chk #(
   .NCH   (NCH),
   .DLY_W (DLY_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mode_sel (mode_sel),
   .thr_cfg  (thr_cfg),
   .dly_cfg  (dly_cfg),
   .hit_in   (hit_in),
   .trig_out (trig_out)
);

// File: tb/coinc_majority_top_test.sv
`timescale 1ns/1ps
module coinc_majority_top_test;
   import coinc_pkg::*;

   localparam int NCH   = 8;
   localparam int DW    = 4;
   localparam int NL    = NLAYER;
   localparam int HW    = NL * NCH;
   localparam int DEPTH = 1 << DW;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic              rst_n;
   logic [MODE_W-1:0] mode_sel;
   logic [THR_W-1:0]  thr_cfg;
   logic [NL*DW-1:0]  dly_cfg;
   logic [HW-1:0]     hit_in;
   logic [NCH-1:0]    trig_out;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   logic [HW-1:0]  hist[$];
   logic [NCH-1:0] exp_trig = '0;

   coinc_majority_top #(.NCH(NCH), .DLY_W(DW)) uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_sel (mode_sel),
      .thr_cfg  (thr_cfg),
      .dly_cfg  (dly_cfg),
      .hit_in   (hit_in),
      .trig_out (trig_out)
   );

   // Behavioural model: type table, threshold rule and delayed history.
   function automatic logic [NCH-1:0] predict(int mode, int thr, logic [NL*DW-1:0] dly);
      logic [NCH-1:0] res;
      int n, dflt, eff;
      res = '0;
      case (mode)
         0, 2:    begin n = 4; dflt = 3; end
         1:       begin n = 3; dflt = 2; end
         3, 4:    begin n = 2; dflt = 1; end
         default: begin n = 0; dflt = 0; end
      endcase
      if (n == 0) return res;
      eff = (thr == 0) ? dflt : ((thr > n) ? n : thr);
      for (int c = 0; c < NCH; c++) begin
         int cnt;
         cnt = 0;
         for (int l = 0; l < n; l++) begin
            int d;
            d = int'(dly[l*DW +: DW]);
            if (hist[d][l*NCH + c]) cnt++;
         end
         res[c] = (cnt >= eff);
      end
      return res;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         hist.delete();
         for (int i = 0; i < DEPTH; i++) hist.push_back('0);
         exp_trig = '0;
      end else begin
         hist.push_front(hit_in);
         void'(hist.pop_back());
         exp_trig = predict(int'(mode_sel), int'(thr_cfg), dly_cfg);
      end
   end

   task automatic check(string tag);
      checks++;
      if (trig_out !== exp_trig) begin
         errors++;
         $display("FAIL %s: trig_out=%h expected=%h at %0t", tag, trig_out, exp_trig, $time);
      end
   endtask

   function automatic logic [HW-1:0] rand_hits(bit sparse);
      logic [HW-1:0] h;
      h = '0;
      if (sparse) begin
         int c;
         c = int'($urandom_range(NCH - 1));
         for (int l = 0; l < NL; l++) h[l*NCH + c] = 1'($urandom_range(1));
      end else begin
         for (int i = 0; i < HW; i++) h[i] = 1'($urandom_range(1));
      end
      return h;
   endfunction

   // mode/thr < 0 pick random legal values; rdly redraws delays every 8 cycles.
   task automatic run(string tag, int mode, int thr, bit rdly, bit sparse, int cycles);
      for (int k = 0; k < cycles; k++) begin
         @(negedge clk);
         check(tag);
         mode_sel = (mode < 0) ? MODE_W'($urandom_range(4)) : MODE_W'(mode);
         thr_cfg  = (thr < 0) ? THR_W'($urandom_range(7)) : THR_W'(thr);
         if (!rdly) dly_cfg = '0;
         else if (k % 8 == 0)
            for (int l = 0; l < NL; l++) dly_cfg[l*DW +: DW] = DW'($urandom_range(DEPTH - 1));
         hit_in = rand_hits(sparse);
      end
   endtask

   initial begin
      rst_n    = 1'b0;
      mode_sel = '0;
      thr_cfg  = '0;
      dly_cfg  = '0;
      hit_in   = '0;
      // R1: output stays clear and hits fed during reset must not leak.
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         checks++;
         if (trig_out !== '0) begin
            errors++;
            $display("FAIL R1: trig_out=%h expected=0 during reset", trig_out);
         end
         hit_in  = '1;
         dly_cfg = {4'd15, 4'd9, 4'd4, 4'd1};
      end
      @(negedge clk);
      hit_in = '0;
      rst_n  = 1'b1;
      run("R1", 0, 0, 1'b0, 1'b0, 1);
      hit_in  = '0;
      dly_cfg = {4'd15, 4'd9, 4'd4, 4'd1};
      run("R1", 0, 1, 1'b1, 1'b1, 0);
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         check("R1");
      end
      run("R2", 0, 0, 1'b0, 1'b0, 80);
      run("R3", 1, 0, 1'b0, 1'b0, 80);
      run("R4", 2, 0, 1'b0, 1'b0, 80);
      run("R5", 3, 0, 1'b0, 1'b0, 60);
      run("R5", 4, 0, 1'b0, 1'b0, 60);
      run("R6", -1, -1, 1'b0, 1'b0, 150);
      run("R7", -1, 0, 1'b1, 1'b0, 300);
      run("R7", -1, -1, 1'b1, 1'b0, 200);
      run("R8", 5, 0, 1'b1, 1'b0, 30);
      run("R8", 6, 1, 1'b1, 1'b0, 30);
      run("R8", 7, 0, 1'b1, 1'b0, 30);
      run("R9", -1, -1, 1'b0, 1'b1, 150);
      run("R9", -1, 0, 1'b1, 1'b1, 100);
      @(negedge clk);
      check("R9");
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=still running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule